// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the fetch address register and, every cycle, turns the current fetch address into the address to fetch next. Two structures are looked up in parallel. The first is a small fully associative cache of branch targets, searched with the whole fetch address. The second is a larger direct-mapped table of 2-bit saturating direction counters. A target cache hit alone would mean "taken", but the counter table has the final say on direction. The next fetch address is the predicted target only when both agree. In every other case it is the sequential address.

When a branch resolves in execute, the resolution port trains both structures. The counter at the branch's index moves one step toward the outcome. A taken branch refreshes its target cache entry, or allocates one in round-robin order. Lookup is combinational from registered state, and every update is written at the clock edge. A prediction therefore reflects all resolutions from earlier cycles and none from the current one.

Top module: `brp_fetch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the target cache holds no valid entries, so `next_fetch_addr` equals `fetch_addr + 4` and `redirect` is 0 for any address.
- R2: When the target cache holds an entry whose branch address equals `fetch_addr` and the selected counter's upper bit is 1, `next_fetch_addr` is that entry's most recent target and `redirect` is 1. Addresses and targets are word aligned, and their two low bits are not stored.
- R3: When the selected counter says taken but the target cache has no matching entry, fetch continues at `fetch_addr + 4` with `redirect` 0.
- R4: When the selected counter's upper bit is 0, fetch is sequential even if the target cache hits.
- R5: The counter is selected by address bits [10:2]. Two branches that differ only in bits above bit 10 share one counter.
- R6: A resolution increments the selected counter on taken and decrements it on not-taken. The counter saturates at 3 and at 0.
- R7: A taken resolution of a branch already in the target cache overwrites that entry's target and allocates nothing. At most one entry ever matches a given address.
- R8: A taken resolution of a branch absent from the target cache writes the slot under a round-robin victim pointer, which then advances. With 64 entries, the 65th distinct allocation evicts the first.
- R9: A not-taken resolution leaves the target cache unchanged, including the target it carries.
- R10: A resolution changes predictions from the next cycle on. A lookup in the same cycle as a resolution of the same address sees the state from before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Current fetch address |
| next_fetch_addr | output | ADDR_W | Predicted address of the next fetch |
| redirect | output | 1 | 1 when `next_fetch_addr` is a predicted target |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
Lookup and training share the same tables, so a fetch and a resolution of the same branch can land in the same cycle. The bench provokes this deliberately on the first training of a branch and on later direction flips. It also lets a long randomised phase, drawn from a small address pool with aliases, produce the overlap many times. The reference model applies each resolution only after the clock edge. Each same-cycle lookup is therefore judged against the state from before the update, and the following cycle against the state after it.

// File: rtl/brp_pkg.sv
package brp_pkg;

    // counter value loaded at reset: weakly not-taken
    localparam logic [1:0] CTR_RESET_VAL = 2'b01;

    // one saturating step of a 2-bit direction counter
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        if (taken)
            return (cur == 2'b11) ? cur : cur + 2'b01;
        else
            return (cur == 2'b00) ? cur : cur - 2'b01;
    endfunction

endpackage

// File: rtl/brp_counter_table.sv
module brp_counter_table
    import brp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } ct_state_t;

    ct_state_t        st_d, st_q;
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [1:0]       up_cur;

    assign lk_idx   = lk_addr[IDX_W+1:2];
    assign up_idx   = upd_addr[IDX_W+1:2];
    assign up_cur   = st_q.ctr[up_idx];
    assign lk_taken = st_q.ctr[lk_idx][1];

    always_comb begin
        st_d = st_q;
        if (upd_valid)
            st_d.ctr[up_idx] = ctr_step(up_cur, upd_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ct_state_t'({ENTRIES{CTR_RESET_VAL}});
        else
            st_q <= st_d;
    end

    // R6
    ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && up_cur == 2'b11) |=> st_q.ctr[$past(up_idx)] == 2'b11);
    // R6
    ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && up_cur == 2'b00) |=> st_q.ctr[$past(up_idx)] == 2'b00);
    // R6
    ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && up_cur != 2'b11) |=>
            st_q.ctr[$past(up_idx)] == $past(up_cur) + 2'b01);

endmodule

// File: rtl/brp_target_cache.sv
module brp_target_cache #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    localparam int TAG_W = ADDR_W - 2;
    localparam int PTR_W = $clog2(ENTRIES);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] tgt;
    } tc_ent_t;

    typedef struct packed {
        tc_ent_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]      victim;
    } tc_state_t;

    tc_state_t        st_d, st_q;
    logic [ENTRIES-1:0] lk_match, up_match;
    logic [TAG_W-1:0] lk_tgt_or;
    logic [PTR_W-1:0] up_slot;
    logic             up_hit;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign lk_match[i] = st_q.ent[i].vld && (st_q.ent[i].tag == lk_addr[ADDR_W-1:2]);
        assign up_match[i] = st_q.ent[i].vld && (st_q.ent[i].tag == upd_addr[ADDR_W-1:2]);
    end

    // lookup: matches are one-hot, so an AND-OR mux selects the target
    always_comb begin
        lk_tgt_or = '0;
        for (int i = 0; i < ENTRIES; i++)
            lk_tgt_or |= {TAG_W{lk_match[i]}} & st_q.ent[i].tgt;
    end

    assign lk_hit    = |lk_match;
    assign lk_target = {lk_tgt_or, 2'b00};

    // update slot encode
    always_comb begin
        up_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (up_match[i]) up_slot = PTR_W'(i);
    end

    assign up_hit = |up_match;

    always_comb begin
        st_d = st_q;
        if (upd_valid && upd_taken) begin
            if (up_hit) begin
                st_d.ent[up_slot].tgt = upd_target[ADDR_W-1:2];
            end else begin
                st_d.ent[st_q.victim].vld = 1'b1;
                st_d.ent[st_q.victim].tag = upd_addr[ADDR_W-1:2];
                st_d.ent[st_q.victim].tgt = upd_target[ADDR_W-1:2];
                st_d.victim = (st_q.victim == LAST_SLOT) ? '0 : st_q.victim + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R7
    tc_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    // R9
    tc_nt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=> $stable(st_q.ent));
    // R8
    tc_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !up_hit) |=>
            (st_q.ent[$past(st_q.victim)].vld &&
             st_q.ent[$past(st_q.victim)].tag == $past(upd_addr[ADDR_W-1:2])));

endmodule

// File: rtl/brp_fetch_predictor.sv
module brp_fetch_predictor #(
    parameter int ADDR_W      = 32,
    parameter int TC_ENTRIES  = 64,
    parameter int CTR_ENTRIES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] next_fetch_addr,
    output logic              redirect,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic              tc_hit, ctr_taken;
    logic [ADDR_W-1:0] tc_target, seq_addr;

    brp_target_cache #(.ADDR_W(ADDR_W), .ENTRIES(TC_ENTRIES)) u_tc (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (fetch_addr),
        .lk_hit     (tc_hit),
        .lk_target  (tc_target),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target)
    );

    brp_counter_table #(.ADDR_W(ADDR_W), .ENTRIES(CTR_ENTRIES)) u_ct (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (fetch_addr),
        .lk_taken  (ctr_taken),
        .upd_valid (upd_valid),
        .upd_addr  (upd_pc),
        .upd_taken (upd_taken)
    );

    // direction from the counter overrides the hit-implies-taken of the cache
    assign seq_addr        = fetch_addr + STEP;
    assign redirect        = tc_hit && ctr_taken;
    assign next_fetch_addr = redirect ? tc_target : seq_addr;

    // R10
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (!$stable(fetch_addr) || $stable(next_fetch_addr)));

endmodule

// File: tb/brp_fetch_predictor_test.sv
module brp_fetch_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fa, nfa, upc, utg;
    logic        redir, uv, ut;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    int          ref_ctr[512];
    logic [31:0] ref_tgt[logic [31:0]];
    logic [31:0] ref_order[$];

    always #10 clk = ~clk;

    brp_fetch_predictor uut (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fa), .next_fetch_addr(nfa),
        .redirect(redir), .upd_valid(uv), .upd_pc(upc), .upd_taken(ut), .upd_target(utg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endfunction

    // one cycle: drive at negedge, compare before posedge, advance model after posedge
    task automatic step(input string req, input logic [31:0] a, input bit v,
                        input logic [31:0] p, input bit t, input logic [31:0] g);
        logic [31:0] exp;
        bit          er;
        int          idx;
        @(negedge clk);
        fa = a; uv = v; upc = p; ut = t; utg = g;
        #8;
        idx = int'(a[10:2]);
        er  = (ref_ctr[idx] >= 2) && ref_tgt.exists(a);
        exp = er ? ref_tgt[a] : a + 32'd4;
        check(req, nfa, exp);
        check(req, {31'b0, redir}, {31'b0, er});
        @(posedge clk);
        if (v && rst_n) begin
            idx = int'(p[10:2]);
            if (t) ref_ctr[idx] = (ref_ctr[idx] == 3) ? 3 : ref_ctr[idx] + 1;
            else   ref_ctr[idx] = (ref_ctr[idx] == 0) ? 0 : ref_ctr[idx] - 1;
            if (t) begin
                if (!ref_tgt.exists(p)) begin
                    if (ref_order.size() == 64) ref_tgt.delete(ref_order.pop_front());
                    ref_order.push_back(p);
                end
                ref_tgt[p] = g;
            end
        end
    endtask

    task automatic look(input string req, input logic [31:0] a);
        step(req, a, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic train(input string req, input logic [31:0] p, input bit t, input logic [31:0] g);
        step(req, 32'h0000_F000, 1'b1, p, t, g);
    endtask

    localparam logic [31:0] BR_A  = 32'h0000_1000;
    localparam logic [31:0] BR_C  = 32'h0000_1800; // same bits [10:2] as BR_A
    localparam logic [31:0] BR_FAR = 32'h0040_1000; // aliases BR_A's counter too

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) ref_ctr[i] = 1;
        rst_n = 1'b0; fa = '0; uv = 1'b0; upc = '0; ut = 1'b0; utg = '0;
        // R1: during reset and right after it, fetch is sequential everywhere
        look("R1", BR_A);
        look("R1", 32'h0000_0000);
        rst_n = 1'b1;
        look("R1", BR_A);
        look("R1", 32'hFFFF_FFF0);

        // R10: fetching A while A resolves taken sees the old (empty) state
        step("R10", BR_A, 1'b1, BR_A, 1'b1, 32'h0000_2000);
        // R2: next cycle the counter is 10 and the cache hits
        look("R2", BR_A);
        // R6: climb to 3 and saturate
        train("R6", BR_A, 1'b1, 32'h0000_2000);
        train("R6", BR_A, 1'b1, 32'h0000_2000);
        train("R6", BR_A, 1'b1, 32'h0000_2000);
        look("R6", BR_A);
        // R9: not-taken resolution carrying a bogus target leaves the cache alone
        train("R9", BR_A, 1'b0, 32'h0000_DEA0);
        look("R9", BR_A);
        // R4: counter falls below 2, hit no longer redirects
        step("R10", BR_A, 1'b1, BR_A, 1'b0, 32'h0000_DEA0);
        look("R4", BR_A);
        // R6: fall to 0 and saturate, then one taken leaves it not-taken
        train("R6", BR_A, 1'b0, 32'h0);
        train("R6", BR_A, 1'b0, 32'h0);
        train("R6", BR_A, 1'b0, 32'h0);
        train("R6", BR_A, 1'b1, 32'h0000_2000);
        look("R6", BR_A);
        train("R6", BR_A, 1'b1, 32'h0000_2000);
        look("R6", BR_A);
        // R7: taken resolution with a new target refreshes the entry
        train("R7", BR_A, 1'b1, 32'h0000_3000);
        look("R7", BR_A);
        // R3: C shares A's taken counter but misses the cache
        look("R3", BR_C);
        look("R3", BR_FAR);
        // R5: training C moves the counter A uses
        train("R5", BR_C, 1'b1, 32'h0000_5000);
        look("R5", BR_C);
        train("R5", BR_C, 1'b0, 32'h0);
        train("R5", BR_C, 1'b0, 32'h0);
        train("R5", BR_C, 1'b0, 32'h0);
        look("R5", BR_A);
        look("R5", BR_C);
        train("R5", BR_A, 1'b1, 32'h0000_3000);
        train("R5", BR_A, 1'b1, 32'h0000_3000);
        look("R5", BR_C);

        // R8: 70 fresh allocations push out the oldest entries in order
        for (int k = 0; k < 70; k++) begin
            train("R8", 32'h0001_0000 + 32'(k * 4), 1'b1, 32'h0002_0000 + 32'(k * 16));
            train("R8", 32'h0001_0000 + 32'(k * 4), 1'b1, 32'h0002_0000 + 32'(k * 16));
        end
        look("R8", BR_A);
        look("R8", BR_C);
        for (int k = 0; k < 70; k++) look("R8", 32'h0001_0000 + 32'(k * 4));

        // mixed traffic with overlapping lookups and resolutions
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, p;
            a = 32'h0000_8000 + 32'(($urandom % 80) * 4) + (($urandom % 4 == 0) ? 32'h800 : 32'h0);
            p = ($urandom % 3 == 0) ? a
                : 32'h0000_8000 + 32'(($urandom % 80) * 4) + (($urandom % 4 == 0) ? 32'h800 : 32'h0);
            step("R10", a, ($urandom % 2) == 0, p, ($urandom % 3) != 0,
                 {$urandom % 32'h0010_0000, 2'b00} & 32'h003F_FFFC);
        end
        look("R2", BR_A);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule